// File: doc/BRIEF.md
# Phase-Staggered RGB PWM Generator

This block produces the on/off gate signals for twelve LED current sinks, grouped as four sets of red, green and blue. Each channel is configured by an 8-bit byte. The low six bits are a duty code that sets how many of the 63 slots in a period the sink conducts. The high two bits pick a coarse current step, 25 % to 100 % of full scale in four equal steps. The block does not use that step itself. It only hands it to the analog side.

One slot counter is shared by all channels. It steps once per slot tick. The slot tick is a base tick divided by 4, 2 or 1, chosen by a 2-bit rate select. Inside a set, the three colours place their pulses differently: red starts at the beginning of the period, green sits around the middle, and blue finishes at the end. Each set's period is shifted by a fixed number of slots from the set before it, so the sets do not all switch on together. A channel can drive only when the global active bit and its set's enable bit are both 1. A new duty code is taken up only at the boundary of that set's period.

Top module: `rgbpwm_top`

## Requirements
- R1: Duty code N (0..63) makes the channel conduct for exactly N of the 63 slots in each period. Code 0 never conducts and code 63 always conducts.
- R2: Red is start-aligned. It conducts in slots 0 to N-1 of its set's period.
- R3: Green is centre-aligned. It conducts from slot 31-floor(N/2) to slot 30+ceil(N/2), so an odd-width pulse puts its extra slot after the centre boundary.
- R4: Blue is end-aligned. It conducts in slots 63-N to 62.
- R5: Slot 0 of set k (k = 0..3) comes 16·k slots (mod 63) after slot 0 of set 0. Channel i = 3·k + c, where c is 0 for red, 1 for green and 2 for blue. Its gate is `sink_on[i]` and its byte is `chan_cfg[8i+7:8i]`.
- R6: Rate select 00 gives a slot of 4 base ticks and 01 gives 2. Select 10 or 11 gives 1. A period is therefore 252, 126 or 63 base ticks long.
- R7: A set's gates stay low while `active` is 0 or that set's `set_en` bit is 0.
- R8: `sink_level[2i+1:2i]` always equals bits [7:6] of channel i's byte.
- R9: A duty code takes effect only at the next slot 0 of its set. Reset clears every held duty code to 0, so all gates stay low until that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_cfg | input | 96 | Twelve channel bytes, channel i in bits [8i+7:8i] |
| rate_sel | input | 2 | Period rate select |
| active | input | 1 | Global standby release |
| set_en | input | 4 | Per-set enable |
| sink_on | output | 12 | Registered gate per channel |
| sink_level | output | 24 | Forwarded current step per channel |

## Verification
A duty rewrite can land while the old pulse is still running and before the set's period boundary. Both the running pulse and the held-code reload depend on the same slot position. The bench rewrites the red code of set 0 a few cycles after its rising edge. It expects the current pulse to keep the old width and the next pulse to have the new one. Phase stagger and alignment are judged together: the bench captures two whole periods, takes the rise of set 0 red as the reference slot, and predicts every slot of all twelve gates from R2–R5.

// File: rtl/rgbpwm_pkg.sv
package rgbpwm_pkg;

    localparam int SLOTS   = 63;
    localparam int DUTY_W  = 6;
    localparam int LEVEL_W = 2;
    localparam int CFG_W   = DUTY_W + LEVEL_W;
    localparam int COLOURS = 3;

    typedef enum logic [1:0] {
        ALIGN_START  = 2'd0,
        ALIGN_CENTRE = 2'd1,
        ALIGN_END    = 2'd2
    } align_e;

    typedef struct packed {
        logic [LEVEL_W-1:0] level;
        logic [DUTY_W-1:0]  duty;
    } chan_cfg_t;

    // Whether a pulse of width d covers slot p for a given alignment.
    function automatic logic pulse_covers(align_e a, logic [DUTY_W-1:0] d,
                                          logic [DUTY_W-1:0] p);
        logic [DUTY_W:0] d7, p7, lo, hi;
        d7 = {1'b0, d};
        p7 = {1'b0, p};
        lo = 7'd31 - {2'b00, d[DUTY_W-1:1]};
        hi = 7'd30 + ((d7 + 7'd1) >> 1);
        case (a)
            ALIGN_START:  return p7 < d7;
            ALIGN_CENTRE: return (p7 >= lo) && (p7 <= hi);
            ALIGN_END:    return (p7 + d7) >= 7'd63;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rgbpwm_tick.sv
module rgbpwm_tick #(
    parameter int BASE_DIV = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rate_sel,
    output logic       tick
);
    localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

    logic       base_tick;
    logic [1:0] pre;

    generate
        if (BASE_DIV > 1) begin : g_div
            logic [BW-1:0] base_cnt;
            always_ff @(posedge clk) begin
                if (rst)                              base_cnt <= '0;
                else if (base_cnt == BW'(BASE_DIV-1)) base_cnt <= '0;
                else                                  base_cnt <= base_cnt + 1'b1;
            end
            assign base_tick = (base_cnt == BW'(BASE_DIV-1));
        end else begin : g_nodiv
            assign base_tick = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)            pre <= '0;
        else if (base_tick) pre <= pre + 1'b1;
    end

    always_comb begin
        if (rate_sel[1])      tick = base_tick;
        else if (rate_sel[0]) tick = base_tick & pre[0];
        else                  tick = base_tick & (&pre);
    end

    // At the slowest rate, two slot ticks are never adjacent.
    assert_slow_gap_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && rate_sel == 2'b00 && $stable(rate_sel)) |=> !tick);

endmodule

// File: rtl/rgbpwm_slot_counter.sv
module rgbpwm_slot_counter
    import rgbpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    output logic [DUTY_W-1:0] slot
);
    always_ff @(posedge clk) begin
        if (rst)                               slot <= '0;
        else if (tick && slot == DUTY_W'(SLOTS-1)) slot <= '0;
        else if (tick)                         slot <= slot + 1'b1;
    end

    assert_range_R5: assert property (@(posedge clk) disable iff (rst)
        slot < DUTY_W'(SLOTS));
    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && slot == DUTY_W'(SLOTS-1)) |=> slot == '0);
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(slot));

endmodule

// File: rtl/rgbpwm_channel.sv
module rgbpwm_channel
    import rgbpwm_pkg::*;
#(
    parameter align_e ALIGN  = ALIGN_START,
    parameter int     OFFSET = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DUTY_W-1:0] slot,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              enable,
    output logic              on
);
    localparam logic [DUTY_W:0] SHIFT = (DUTY_W+1)'(SLOTS - OFFSET);

    logic [DUTY_W:0]   sum;
    logic [DUTY_W-1:0] pos;
    logic [DUTY_W-1:0] duty_q;
    logic              load;

    always_comb begin
        sum  = {1'b0, slot} + SHIFT;
        pos  = (sum >= 7'd63) ? DUTY_W'(sum - 7'd63) : DUTY_W'(sum);
        load = tick && (pos == DUTY_W'(SLOTS-1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
            on     <= 1'b0;
        end else begin
            if (load) duty_q <= duty_in;
            on <= enable & pulse_covers(ALIGN, duty_q, pos);
        end
    end

    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !on);
    assert_latch_R9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(duty_q));
    assert_full_R1: assert property (@(posedge clk) disable iff (rst)
        (enable && duty_q == 6'd63) |=> on);
    assert_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (duty_q == 6'd0) |=> !on);

endmodule

// File: rtl/rgbpwm_top.sv
module rgbpwm_top
    import rgbpwm_pkg::*;
#(
    parameter int NUM_SETS = 4,
    parameter int SET_STEP = 16,
    parameter int BASE_DIV = 20
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_SETS*COLOURS*CFG_W-1:0]   chan_cfg,
    input  logic [1:0]                          rate_sel,
    input  logic                                active,
    input  logic [NUM_SETS-1:0]                 set_en,
    output logic [NUM_SETS*COLOURS-1:0]         sink_on,
    output logic [NUM_SETS*COLOURS*LEVEL_W-1:0] sink_level
);
    localparam int NCH = NUM_SETS * COLOURS;

    logic              tick;
    logic [DUTY_W-1:0] slot;
    chan_cfg_t         cfg [NCH];

    rgbpwm_tick #(.BASE_DIV(BASE_DIV)) u_tick (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .tick(tick)
    );

    rgbpwm_slot_counter u_slot (
        .clk(clk), .rst(rst), .tick(tick), .slot(slot)
    );

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
            for (genvar c = 0; c < COLOURS; c++) begin : g_col
                localparam int IDX = s * COLOURS + c;
                assign cfg[IDX] = chan_cfg[IDX*CFG_W +: CFG_W];
                assign sink_level[IDX*LEVEL_W +: LEVEL_W] = cfg[IDX].level;
                rgbpwm_channel #(
                    .ALIGN  (align_e'(c)),
                    .OFFSET ((SET_STEP * s) % SLOTS)
                ) u_ch (
                    .clk     (clk),
                    .rst     (rst),
                    .tick    (tick),
                    .slot    (slot),
                    .duty_in (cfg[IDX].duty),
                    .enable  (active & set_en[s]),
                    .on      (sink_on[IDX])
                );
            end
        end
    endgenerate

endmodule

// File: tb/rgbpwm_top_test.sv
module rgbpwm_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [95:0] chan_cfg = '0;
    logic [1:0]  rate_sel = 2'b10;
    logic        active = 1'b0;
    logic [3:0]  set_en = 4'b0000;
    logic [11:0] sink_on;
    logic [23:0] sink_level;

    int errors = 0;
    int checks = 0;
    int duty [12];
    int lvl  [12];
    logic [11:0] cap [126];

    always #10 clk = ~clk;

    rgbpwm_top #(.BASE_DIV(1)) uut (
        .clk(clk), .rst(rst), .chan_cfg(chan_cfg), .rate_sel(rate_sel),
        .active(active), .set_en(set_en), .sink_on(sink_on),
        .sink_level(sink_level)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_on(input int colour, input int d, input int p);
        case (colour)
            0: return p < d;
            1: return (p >= 31 - d / 2) && (p <= 30 + (d + 1) / 2);
            default: return p >= 63 - d;
        endcase
    endfunction

    task automatic apply_cfg();
        for (int i = 0; i < 12; i++)
            chan_cfg[i*8 +: 8] = {lvl[i][1:0], duty[i][5:0]};
    endtask

    task automatic capture();
        for (int i = 0; i < 126; i++) begin
            @(negedge clk);
            cap[i] = sink_on;
        end
    endtask

    // Finds the first rise of set 0 red in the capture; -1 if none.
    function automatic int red0_rise();
        for (int i = 1; i < 126; i++)
            if (cap[i][0] && !cap[i-1][0]) return i;
        return -1;
    endfunction

    task automatic test_reset();
        for (int i = 0; i < 12; i++) begin duty[i] = 63; lvl[i] = (i * 7) % 4; end
        apply_cfg();
        active = 1'b1; set_en = 4'hF; rate_sel = 2'b10;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                seen |= int'(sink_on);
            end
            check(seen == 0, "R9 reset holds gates low", seen, 0);
        end
        begin
            int bad = 0;
            for (int i = 0; i < 12; i++)
                if (sink_level[2*i +: 2] != lvl[i][1:0]) bad++;
            check(bad == 0, "R8 level forwarding", bad, 0);
        end
    endtask

    task automatic test_pattern(input string name, input int d [12], input bit count_too);
        int r0;
        duty = d;
        for (int i = 0; i < 12; i++) lvl[i] = (i + 1) % 4;
        apply_cfg();
        active = 1'b1; set_en = 4'hF; rate_sel = 2'b11;
        repeat (200) @(negedge clk);
        begin
            int bad = 0;
            for (int i = 0; i < 12; i++)
                if (sink_level[2*i +: 2] != lvl[i][1:0]) bad++;
            check(bad == 0, "R8 level forwarding under pattern", bad, 0);
        end
        capture();
        r0 = red0_rise();
        check(r0 >= 0, "R2 set 0 red rise found", r0, 1);
        if (r0 < 0) return;
        for (int ch = 0; ch < 12; ch++) begin
            int k = ch / 3;
            int c = ch % 3;
            int mism = 0;
            int ons = 0;
            for (int i = 0; i < 126; i++) begin
                int p = ((i - r0 - 16 * k) % 63 + 126) % 63;
                if (cap[i][ch] != model_on(c, d[ch], p)) mism++;
                if (i < 63 && cap[i][ch]) ons++;
            end
            // R2 red, R3 green, R4 blue; R5 stagger for sets 1..3
            if (c == 0)      check(mism == 0, $sformatf("R2/R5 %s ch%0d slot mismatches", name, ch), mism, 0);
            else if (c == 1) check(mism == 0, $sformatf("R3/R5 %s ch%0d slot mismatches", name, ch), mism, 0);
            else             check(mism == 0, $sformatf("R4/R5 %s ch%0d slot mismatches", name, ch), mism, 0);
            if (count_too)
                check(ons == d[ch], $sformatf("R1 %s ch%0d on-slots per period", name, ch), ons, d[ch]);
        end
    endtask

    task automatic test_gating();
        int d [12] = '{10, 7, 20, 1, 2, 63, 62, 33, 0, 31, 32, 5};
        duty = d; apply_cfg();
        rate_sel = 2'b11; set_en = 4'hF; active = 1'b0;
        repeat (3) @(negedge clk);
        capture();
        begin
            int hits = 0;
            for (int i = 0; i < 126; i++) if (cap[i] != 0) hits++;
            check(hits == 0, "R7 inactive keeps all gates low", hits, 0);
        end
        active = 1'b1; set_en = 4'b0101;
        repeat (3) @(negedge clk);
        capture();
        begin
            int off_hits = 0, red0 = 0, red2 = 0;
            for (int i = 0; i < 126; i++) begin
                if ((cap[i] & 12'hE38) != 0) off_hits++;
                if (cap[i][0]) red0++;
                if (cap[i][6]) red2++;
            end
            check(off_hits == 0, "R7 disabled sets 1 and 3 stay low", off_hits, 0);
            check(red0 == 20, "R7 enabled set 0 red drives", red0, 20);
            check(red2 == 124, "R7 enabled set 2 red drives", red2, 124);
        end
        set_en = 4'hF;
    endtask

    task automatic measure_red0(output int width, output int period);
        int guard = 0;
        logic prev;
        width = 0; period = 0;
        @(negedge clk); prev = sink_on[0];
        while (!(sink_on[0] && !prev) && guard < 1000) begin
            prev = sink_on[0]; @(negedge clk); guard++;
        end
        while (sink_on[0] && guard < 2000) begin
            width++; period++; @(negedge clk); guard++;
        end
        while (!sink_on[0] && guard < 3000) begin
            period++; @(negedge clk); guard++;
        end
    endtask

    task automatic test_rate(input logic [1:0] sel, input int slot_len);
        int w, p;
        duty[0] = 10; apply_cfg();
        rate_sel = sel;
        repeat (600) @(negedge clk);
        measure_red0(w, p);
        check(w == 10 * slot_len, $sformatf("R6 rate %0b pulse width", sel), w, 10 * slot_len);
        check(p == 63 * slot_len, $sformatf("R6 rate %0b period", sel), p, 63 * slot_len);
    endtask

    task automatic test_latch();
        int w1 = 0, w2, p2;
        int guard = 0;
        logic prev;
        duty[0] = 10; apply_cfg();
        rate_sel = 2'b11;
        repeat (200) @(negedge clk);
        @(negedge clk); prev = sink_on[0];
        while (!(sink_on[0] && !prev) && guard < 500) begin
            prev = sink_on[0]; @(negedge clk); guard++;
        end
        for (int i = 0; i < 3; i++) begin
            if (sink_on[0]) w1++;
            @(negedge clk);
        end
        duty[0] = 30; apply_cfg();
        while (sink_on[0] && guard < 1000) begin
            w1++; @(negedge clk); guard++;
        end
        check(w1 == 10, "R9 pulse in progress keeps old width", w1, 10);
        measure_red0(w2, p2);
        check(w2 == 30, "R9 next period uses new code", w2, 30);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int pa [12] = '{10, 7, 20, 1, 2, 63, 62, 33, 0, 31, 32, 5};
        int pb [12] = '{45, 1, 3, 0, 63, 62, 17, 62, 63, 50, 11, 8};
        test_reset();
        test_pattern("A", pa, 1'b1);
        test_pattern("B", pb, 1'b1);
        test_gating();
        test_rate(2'b00, 4);
        test_rate(2'b01, 2);
        test_rate(2'b10, 1);
        test_rate(2'b11, 1);
        test_latch();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule